// File: doc/BRIEF.md
# Clock Distribution Sync and Deep-Sleep Controller

This block decides when every output divider of a clock distribution tree is
realigned, and when the whole distribution tree may be put into its deepest
power state. It issues a single broadcast sync strobe, one clock long, that all
channel dividers consume at the same time. Three sources can request that
strobe:

- a self-clearing software bit;
- an external sync pin, which may change at any time relative to the local clock and is brought into the clock domain here;
- the first lock of the PLL after a reset or a chip power-down.

Lock events after that first lock are not acted on. Only a fresh reset or power-down makes the PLL lock count again.

The deep-sleep flag is a pure function of the per-channel power-down bits. It is
high only while every channel is powered down, and it drops in the same cycle
that any channel is brought back.

Top module: `dist_sync_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `sync_strobe` is low after that edge, and the auto-sync record is cleared.
- R2: A cycle in which `sw_sync` is high at a rising edge gives `sync_strobe` high for the clock cycle that follows that edge.
- R3: A rising transition of `sync_pin` first sampled high at edge k (low at edge k-1) gives `sync_strobe` high for exactly the cycle after edge k+2. Holding the pin high afterwards gives no further strobe.
- R4: The first rising edge of `pll_locked` seen after reset gives `sync_strobe` high for the cycle after the edge at which it is first sampled high. That edge also marks the auto-sync as spent.
- R5: Once the auto-sync is spent, further falls and rises of `pll_locked` produce no strobe until a reset or a chip power-down.
- R6: `sync_strobe` is high for one cycle per request cycle. Several sources requesting at the same edge give a single one-cycle strobe, and a strobe never appears without a request at the previous edge.
- R7: `deep_sleep` is high exactly when all `NUM_CH` bits of `ch_pd` are 1. It is combinational, so it falls in the same cycle that any bit clears.
- R8: While `chip_pd` is high, no auto-sync is issued and the auto-sync record is cleared. Lock is then treated as low, so a PLL still locked when `chip_pd` falls gives one auto strobe in the cycle after the first edge with `chip_pd` low.
- R9: If `pll_locked` is already high when reset ends, that counts as the first lock. `sync_strobe` is then high for the cycle after the first edge with `rst_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Distribution control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_sync | input | 1 | Self-clearing software sync request, synchronous to `clk` |
| sync_pin | input | 1 | External sync pin, asynchronous to `clk` |
| pll_locked | input | 1 | PLL lock indicator, synchronous to `clk` |
| chip_pd | input | 1 | Global power-down; re-arms the automatic sync |
| ch_pd | input | NUM_CH | Per-channel power-down bits |
| sync_strobe | output | 1 | One-cycle sync strobe broadcast to all channel dividers |
| deep_sleep | output | 1 | High when every channel is powered down |

## Verification
The bench builds the block with its defaults: `NUM_CH` = 14 and `SYNC_STAGES` = 2.

Fourteen channels let every single-bit release of `ch_pd` be walked from the all-down state, so the same-cycle fall of `deep_sleep` is seen for each position. The two-stage synchronizer fixes the pin latency at three edges. This makes it possible to line a pin edge up with a software pulse in the same request cycle.

A behavioural model compares the strobe on every cycle through these scenarios:
- lock toggling after the first lock;
- a power-down with the PLL still locked;
- a reset released while already locked.

// File: rtl/dsc_pkg.sv
// Package: shared types for the distribution sync controller.
// Assumes: nothing beyond IEEE 1800-2017 packed structs.
package dsc_pkg;

    // One flag per strobe source, gathered at the same edge.
    typedef struct packed {
        logic sw;    // software register bit
        logic pin;   // synchronized pin rising edge
        logic lock;  // automatic first-lock sync
    } sync_req_t;

endpackage

// File: rtl/dsc_pin_sync.sv
// Module: brings the asynchronous sync pin into the clock domain through a
// STAGES-deep flop chain and reports a single-cycle rising edge.
// Assumes: STAGES >= 2; a held high level gives only one rise pulse.
module dsc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          prev;

    // Shift the pin through the synchronizer and keep one older copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[LAST-1:0], pin_async};
            prev  <= chain[LAST];
        end
    end

    // Rising edge of the synchronized level.
    assign rise = chain[LAST] & ~prev;

endmodule

// File: rtl/dsc_auto_sync.sv
// Module: fires one automatic sync request on the first PLL lock after reset
// or after a chip power-down, then stays quiet until re-armed.
// Assumes: pll_locked is synchronous to clk; chip_pd re-arms like reset.
module dsc_auto_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic chip_pd,
    input  logic pll_locked,
    output logic fire,
    output logic done
);
    logic lock_q;
    logic done_q;

    // Request only on a lock rise while armed and not powered down.
    assign fire = pll_locked & ~lock_q & ~done_q & ~chip_pd;
    assign done = done_q;

    // Track previous lock level and the spent flag; power-down re-arms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            done_q <= 1'b0;
        end else if (chip_pd) begin
            lock_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            lock_q <= pll_locked;
            if (fire) begin
                done_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dsc_sleep_detect.sv
// Module: raises all_down when every channel power-down bit is set.
// Assumes: purely combinational so release is seen in the same cycle.
module dsc_sleep_detect #(
    parameter int NUM_CH = 14
) (
    input  logic [NUM_CH-1:0] ch_pd,
    output logic              all_down
);
    logic [NUM_CH:0] acc;

    assign acc[0] = 1'b1;

    // AND chain across the channels, one link per channel.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_link
        assign acc[g+1] = acc[g] & ch_pd[g];
    end

    assign all_down = acc[NUM_CH];

endmodule

// File: rtl/dist_sync_ctrl.sv
// Module: top of the distribution sync and deep-sleep controller. ORs the
// software, pin and first-lock requests into one registered one-cycle strobe
// and reports deep sleep when all channels are down.
// Assumes: synchronous active-low reset; sw_sync and pll_locked are in the
// clk domain; sync_pin is asynchronous.
module dist_sync_ctrl #(
    parameter int NUM_CH      = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_sync,
    input  logic              sync_pin,
    input  logic              pll_locked,
    input  logic              chip_pd,
    input  logic [NUM_CH-1:0] ch_pd,
    output logic              sync_strobe,
    output logic              deep_sleep
);
    import dsc_pkg::*;

    logic      pin_rise;
    logic      auto_fire;
    logic      auto_done;
    sync_req_t req;
    logic      strobe_q;

    dsc_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (sync_pin),
        .rise      (pin_rise)
    );

    dsc_auto_sync u_auto (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_pd    (chip_pd),
        .pll_locked (pll_locked),
        .fire       (auto_fire),
        .done       (auto_done)
    );

    dsc_sleep_detect #(.NUM_CH(NUM_CH)) u_sleep (
        .ch_pd    (ch_pd),
        .all_down (deep_sleep)
    );

    // Gather the three request sources for this edge.
    always_comb begin
        req.sw   = sw_sync;
        req.pin  = pin_rise;
        req.lock = auto_fire;
    end

    // Register the OR of all requests into a single-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= |req;
        end
    end

    assign sync_strobe = strobe_q;

endmodule

// File: rtl/dsc_checker.sv
// Module: assertion checker for dist_sync_ctrl, attached by bind below.
module dsc_checker #(
    parameter int NUM_CH = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_sync,
    input logic              pll_locked,
    input logic              chip_pd,
    input logic [NUM_CH-1:0] ch_pd,
    input logic              sync_strobe,
    input logic              deep_sleep,
    input logic              pin_rise,
    input logic              auto_fire,
    input logic              auto_done
);
    // R2: software request gives a strobe on the next cycle
    a_r2_sw_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        sw_sync |=> sync_strobe);

    // R3: the pin edge detector never reports two rises in a row
    a_r3_pin_single: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rise |=> !pin_rise);

    // R4: an automatic fire marks the auto-sync as spent
    a_r4_auto_spent: assert property (@(posedge clk) disable iff (!rst_n)
        auto_fire |=> auto_done);

    // R5: the spent record holds while not powered down
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_done && !chip_pd) |=> auto_done);

    // R5: a later lock rise alone brings no strobe
    a_r5_relock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_done && !chip_pd && $rose(pll_locked) && !sw_sync && !pin_rise)
        |=> !sync_strobe);

    // R6: every strobe has a request at the previous edge
    a_r6_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        sync_strobe |-> $past(sw_sync || pin_rise || auto_fire));

    // R7: deep sleep matches a full count of powered-down channels
    a_r7_sleep_all: assert property (@(posedge clk) disable iff (!rst_n)
        deep_sleep == ($countones(ch_pd) == NUM_CH));

    // R8: power-down clears the auto-sync record
    a_r8_pd_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        chip_pd |=> !auto_done);

endmodule

bind dist_sync_ctrl dsc_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_sync     (sw_sync),
    .pll_locked  (pll_locked),
    .chip_pd     (chip_pd),
    .ch_pd       (ch_pd),
    .sync_strobe (sync_strobe),
    .deep_sleep  (deep_sleep),
    .pin_rise    (pin_rise),
    .auto_fire   (auto_fire),
    .auto_done   (auto_done)
);

// File: tb/sim_dist_sync_ctrl.sv
module sim_dist_sync_ctrl;
    localparam int N = 14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sw_sync = 1'b0;
    logic         sync_pin = 1'b0;
    logic         pll_locked = 1'b0;
    logic         chip_pd = 1'b0;
    logic [N-1:0] ch_pd = '0;
    logic         sync_strobe;
    logic         deep_sleep;

    int  n_chk = 0;
    int  n_bad = 0;
    int  cyc = 0;
    int  strobes = 0;
    bit  done_run = 1'b0;

    // Behavioural reference state
    int  pin_hist[$];
    int  lock_prev = 0;
    int  spent = 0;
    int  exp_strobe = 0;

    always #5 clk = ~clk;

    dist_sync_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sw_sync(sw_sync), .sync_pin(sync_pin),
        .pll_locked(pll_locked), .chip_pd(chip_pd), .ch_pd(ch_pd),
        .sync_strobe(sync_strobe), .deep_sleep(deep_sleep)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model: pin seen high 2 edges ago and low 3 edges ago = rise
    always @(posedge clk) begin
        int rise;
        int auto_req;
        cyc++;
        if (!rst_n) begin
            pin_hist = '{0, 0, 0};
            lock_prev = 0;
            spent = 0;
            exp_strobe = 0;
        end else begin
            rise = (pin_hist[1] == 1 && pin_hist[0] == 0) ? 1 : 0;
            auto_req = (pll_locked && lock_prev == 0 && spent == 0 && !chip_pd) ? 1 : 0;
            exp_strobe = (sw_sync || rise == 1 || auto_req == 1) ? 1 : 0;
            if (auto_req == 1) spent = 1;
            if (chip_pd) begin
                spent = 0;
                lock_prev = 0;
            end else begin
                lock_prev = pll_locked ? 1 : 0;
            end
            pin_hist.push_back(sync_pin ? 1 : 0);
            void'(pin_hist.pop_front());
        end
        if (cyc > 20000 && !done_run) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // Per-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(sync_strobe == exp_strobe[0], "R6 strobe vs model", int'(sync_strobe), exp_strobe);
            chk(deep_sleep == (ch_pd == '1), "R7 sleep vs model", int'(deep_sleep), int'(ch_pd == '1));
            if (sync_strobe) strobes++;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int base;
        tick(3);
        chk(sync_strobe == 1'b0, "R1 strobe low in reset", int'(sync_strobe), 0);
        rst_n = 1'b1;
        tick(2);
        chk(sync_strobe == 1'b0, "R1 strobe low after reset", int'(sync_strobe), 0);

        // R2: software pulse
        sw_sync = 1'b1; tick(1); sw_sync = 1'b0;
        chk(sync_strobe == 1'b1, "R2 sw strobe", int'(sync_strobe), 1);
        tick(1);
        chk(sync_strobe == 1'b0, "R2 sw strobe one cycle", int'(sync_strobe), 0);

        // R3: pin held high
        base = strobes;
        sync_pin = 1'b1; tick(2);
        chk(sync_strobe == 1'b0, "R3 pin latency not yet", int'(sync_strobe), 0);
        tick(1);
        chk(sync_strobe == 1'b1, "R3 pin strobe", int'(sync_strobe), 1);
        tick(10);
        chk(strobes - base == 1, "R3 held pin single strobe", strobes - base, 1);
        sync_pin = 1'b0; tick(4);

        // R4: first lock
        pll_locked = 1'b1; tick(1);
        chk(sync_strobe == 1'b1, "R4 first lock strobe", int'(sync_strobe), 1);
        tick(1);
        chk(sync_strobe == 1'b0, "R4 single auto strobe", int'(sync_strobe), 0);

        // R5: relock cycles
        base = strobes;
        for (int k = 0; k < 3; k++) begin
            pll_locked = 1'b0; tick(3);
            pll_locked = 1'b1; tick(3);
        end
        chk(strobes == base, "R5 relock no strobe", strobes - base, 0);

        // R6: pin and sw requests at the same edge
        base = strobes;
        sync_pin = 1'b1; tick(2);
        sw_sync = 1'b1; tick(1); sw_sync = 1'b0;
        chk(sync_strobe == 1'b1, "R6 coincident strobe", int'(sync_strobe), 1);
        tick(1);
        chk(sync_strobe == 1'b0, "R6 coincident one cycle", int'(sync_strobe), 0);
        chk(strobes - base == 1, "R6 coincident count", strobes - base, 1);
        sync_pin = 1'b0; tick(4);

        // R8: power-down with lock held
        base = strobes;
        chip_pd = 1'b1; tick(3);
        chk(strobes == base, "R8 no auto in power-down", strobes - base, 0);
        chip_pd = 1'b0; tick(1);
        chk(sync_strobe == 1'b1, "R8 rearmed lock strobe", int'(sync_strobe), 1);
        tick(4);
        chk(strobes - base == 1, "R8 single rearmed strobe", strobes - base, 1);

        // R7: deep sleep patterns
        ch_pd = '1; #1;
        chk(deep_sleep == 1'b1, "R7 all down sleep", int'(deep_sleep), 1);
        for (int b = 0; b < N; b++) begin
            ch_pd = '1; #1;
            ch_pd[b] = 1'b0; #1;
            chk(deep_sleep == 1'b0, "R7 release same cycle", int'(deep_sleep), 0);
        end
        ch_pd = 14'h1555; tick(1);
        chk(deep_sleep == 1'b0, "R7 partial pattern", int'(deep_sleep), 0);
        ch_pd = '0; tick(1);

        // R9: reset released while locked
        rst_n = 1'b0; pll_locked = 1'b1; tick(3);
        chk(sync_strobe == 1'b0, "R1 strobe low in second reset", int'(sync_strobe), 0);
        rst_n = 1'b1; tick(1);
        chk(sync_strobe == 1'b1, "R9 locked at reset exit", int'(sync_strobe), 1);
        tick(1);
        chk(sync_strobe == 1'b0, "R9 single strobe", int'(sync_strobe), 0);
        tick(5);

        done_run = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule